// File: doc/BRIEF.md
# Independent Windowed Watchdog Timer

This block is a watchdog that runs on its own slow clock, typically near 40 kHz, which is apart from the system bus clock. The slow clock feeds a prescaler, and the prescaler ticks a 12-bit downcounter. Software controls the block by writing 16-bit words to four bus addresses. A start word arms the watchdog. A refresh word reloads the count, but only while the count is at or below a programmable window value. A refresh that arrives while the count is still above the window is treated as a fault.

In reset mode, an expiry or an early refresh drives a reset-request pulse of fixed length. A sticky flag records that such a request occurred. In timer mode, the same events only raise a timeout flag and the counter wraps back to the reload value. A strap input can start the watchdog straight out of reset. A debug-halt input freezes the count. Once running, the watchdog cannot be stopped by software.

Bus writes cross into the watchdog clock through a toggle handshake. A busy output stays high until the slow domain has applied the update. The slow domain runs a three-state machine:
- ST_IDLE: stopped, and the counter tracks the reload value. It goes to ST_RUN on the strap or on the start word.
- ST_RUN: counting. It goes to ST_FIRE on an expiry or an early refresh, in reset mode only.
- ST_FIRE: drives the reset request. It returns to ST_RUN after PULSE_LEN cycles, with the count reloaded.

Top module: `idwdg`

## Requirements
- R1: After reset, rst_req, tmo_flag, rst_seen and busy are all 0. The watchdog is stopped unless hw_start is high.
- R2: Writing 16'hBEEF to address 0 starts the watchdog. Without a start, no reset request is ever raised.
- R3: When hw_start is high at the release of reset, the watchdog starts with no software write.
- R4: In reset mode, the counter expires after (reload+1) prescaler periods. rst_req then goes high for exactly PULSE_LEN watchdog cycles, and rst_seen becomes 1 and stays 1 until reset.
- R5: Writing 16'hFEED to address 0 while the count is at or below the window value reloads the counter. A watchdog refreshed often enough never requests a reset.
- R6: A refresh while the count is above the window value is an early fault. In reset mode it raises a reset request.
- R7: Timer mode is bit 3 = 1 at address 1. In timer mode, an expiry sets tmo_flag and never raises rst_req. A valid refresh clears tmo_flag.
- R8: Configuration writes are accepted only after the unlock word 16'hC0DE has been written to address 0. The fields are: address 1 holds {mode bit 3, divider select bits 2:0}, address 2 holds the reload in bits 11:0, and address 3 holds the window in bits 11:0. Any other value written to address 0 locks the registers again. A dropped write leaves busy at 0.
- R9: The prescaler divides by 4 << sel for sel 0..6. sel 7 also divides by 256.
- R10: While dbg_halt is high, the counter does not advance and no expiry occurs. Counting resumes when dbg_halt falls.
- R11: Once started, no bus write stops the watchdog. After a reset pulse it keeps counting from the reload value.
- R12: busy goes high in the bus cycle after an accepted write and falls once the watchdog domain has applied it. Command and data are held stable while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 key, 1 mode/divider, 2 reload, 3 window) |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Update still in flight to the watchdog domain |
| wd_clk | input | 1 | Independent watchdog clock |
| wd_rst_n | input | 1 | Watchdog-domain reset, active low |
| hw_start | input | 1 | Strap: start automatically out of reset |
| dbg_halt | input | 1 | Debug halt, freezes the count |
| rst_req | output | 1 | Reset request pulse |
| tmo_flag | output | 1 | Timeout flag in timer mode |
| rst_seen | output | 1 | Sticky record of a reset request |

## Verification
On every cycle, the assertions check the following:
- a started watchdog never returns to ST_IDLE;
- the count stays frozen under debug halt;
- timer mode never enters ST_FIRE;
- the reset pulse lasts its full length and rst_seen stays sticky;
- the handshake holds its command stable while busy;
- a locked configuration write never raises busy.

Only the bench scenarios can show end-to-end timing across both clocks: expiry after the programmed reload and divider, refresh inside versus outside the window, the strap start, and the lock and relock behaviour of the unlock word.

// File: rtl/idwdg_pkg.sv
package idwdg_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_REFRESH,
        OP_MODE,
        OP_RELOAD,
        OP_WINDOW
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIRE
    } state_e;

    localparam logic [1:0]  ADDR_KEY     = 2'd0;
    localparam logic [1:0]  ADDR_MODE    = 2'd1;
    localparam logic [1:0]  ADDR_RELOAD  = 2'd2;
    localparam logic [1:0]  ADDR_WINDOW  = 2'd3;

    localparam logic [15:0] KEY_UNLOCK   = 16'hC0DE;
    localparam logic [15:0] KEY_START    = 16'hBEEF;
    localparam logic [15:0] KEY_REFRESH  = 16'hFEED;

endpackage

// File: rtl/idwdg_sync.sv
module idwdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/idwdg_bus_if.sv
module idwdg_bus_if
    import idwdg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_tgl_s,
    output logic              req_tgl,
    output op_e               cmd_op,
    output logic [CNT_W-1:0]  cmd_data,
    output logic              busy
);
    logic unlocked;
    logic take;

    assign busy = req_tgl ^ ack_tgl_s;
    assign take = wr_en && !busy;

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            unlocked <= 1'b0;
            req_tgl  <= 1'b0;
            cmd_op   <= OP_NONE;
            cmd_data <= '0;
        end else if (take) begin
            if (wr_addr == ADDR_KEY) begin
                unlocked <= (wr_data == KEY_UNLOCK);
                if (wr_data == KEY_START) begin
                    cmd_op  <= OP_START;
                    req_tgl <= ~req_tgl;
                end else if (wr_data == KEY_REFRESH) begin
                    cmd_op  <= OP_REFRESH;
                    req_tgl <= ~req_tgl;
                end
            end else if (unlocked) begin
                unique case (wr_addr)
                    ADDR_MODE:   cmd_op <= OP_MODE;
                    ADDR_RELOAD: cmd_op <= OP_RELOAD;
                    default:     cmd_op <= OP_WINDOW;
                endcase
                cmd_data <= wr_data[CNT_W-1:0];
                req_tgl  <= ~req_tgl;
            end
        end
    end

    // R12: command held stable across the handshake
    p_cmd_hold_r12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy |=> ($stable(cmd_data) && $stable(cmd_op)));

    // R8: a locked configuration write starts no handshake
    p_locked_drop_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (take && !unlocked && wr_addr != ADDR_KEY) |=> !busy);
endmodule

// File: rtl/idwdg_core.sv
module idwdg_core
    import idwdg_pkg::*;
#(
    parameter int               CNT_W       = 12,
    parameter int               PRE_W       = 8,
    parameter int               PSEL_W      = 3,
    parameter int               PULSE_LEN   = 4,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             wd_clk,
    input  logic             wd_rst_n,
    input  logic             req_s,
    input  op_e              cmd_op,
    input  logic [CNT_W-1:0] cmd_data,
    input  logic             hw_start,
    input  logic             halt_s,
    output logic             ack_tgl,
    output logic             rst_req,
    output logic             tmo_flag,
    output logic             rst_seen
);
    localparam int              PW        = $clog2(PULSE_LEN + 1);
    localparam logic [PSEL_W-1:0] MAX_SHIFT = PSEL_W'(PRE_W - 2);

    state_e            st, nxt;
    logic              req_d;
    logic              new_cmd;
    logic [PSEL_W-1:0] psel, psel_eff;
    logic              timer_mode;
    logic [CNT_W-1:0]  reload, window, cnt;
    logic [PRE_W-1:0]  pre, pre_last;
    logic [PRE_W:0]    div_full, div_m1;
    logic [PW-1:0]     pulse;
    logic              tick, refresh_cmd, start_cmd, early, good_refresh, expire;

    assign new_cmd      = req_s ^ req_d;
    assign ack_tgl      = req_d;
    assign start_cmd    = new_cmd && (cmd_op == OP_START);
    assign refresh_cmd  = new_cmd && (cmd_op == OP_REFRESH) && (st == ST_RUN);

    // prescaler divide ratio: 4 << sel, clamped at the top value
    assign psel_eff = (psel > MAX_SHIFT) ? MAX_SHIFT : psel;
    assign div_full = (PRE_W + 1)'(4) << psel_eff;
    assign div_m1   = div_full - 1'b1;
    assign pre_last = div_m1[PRE_W-1:0];
    assign tick     = (pre == pre_last) && !halt_s;

    assign early        = refresh_cmd && (cnt > window);
    assign good_refresh = refresh_cmd && !early;
    assign expire       = tick && (cnt == '0) && !refresh_cmd;

    // state register
    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) st <= ST_IDLE;
        else           st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (hw_start || start_cmd)               nxt = ST_RUN;
            ST_RUN:  if (!timer_mode && (early || expire))    nxt = ST_FIRE;
            ST_FIRE: if (pulse == PW'(PULSE_LEN - 1))         nxt = ST_RUN;
            default:                                          nxt = ST_IDLE;
        endcase
    end

    // datapath and flags
    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) begin
            req_d      <= 1'b0;
            psel       <= '0;
            timer_mode <= 1'b0;
            reload     <= RELOAD_INIT;
            window     <= '1;
            cnt        <= RELOAD_INIT;
            pre        <= '0;
            pulse      <= '0;
            tmo_flag   <= 1'b0;
            rst_seen   <= 1'b0;
        end else begin
            req_d <= req_s;
            if (new_cmd) begin
                unique case (cmd_op)
                    OP_MODE:   {timer_mode, psel} <= cmd_data[PSEL_W:0];
                    OP_RELOAD: reload <= cmd_data;
                    OP_WINDOW: window <= cmd_data;
                    default:   ;
                endcase
            end
            unique case (st)
                ST_RUN: begin
                    if (good_refresh) begin
                        cnt      <= reload;
                        pre      <= '0;
                        tmo_flag <= 1'b0;
                    end else if (early) begin
                        if (timer_mode) tmo_flag <= 1'b1;
                    end else if (!halt_s) begin
                        if (tick) begin
                            pre <= '0;
                            if (cnt == '0) begin
                                cnt <= reload;
                                if (timer_mode) tmo_flag <= 1'b1;
                            end else begin
                                cnt <= cnt - 1'b1;
                            end
                        end else begin
                            pre <= pre + 1'b1;
                        end
                    end
                end
                ST_FIRE: begin
                    cnt   <= reload;
                    pre   <= '0;
                    pulse <= pulse + 1'b1;
                end
                default: begin
                    cnt <= reload;
                    pre <= '0;
                end
            endcase
            if (nxt == ST_FIRE && st != ST_FIRE) begin
                rst_seen <= 1'b1;
                pulse    <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        rst_req = (st == ST_FIRE);
    end

    // R11: no way back to stopped once running
    p_no_stop_r11: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (st != ST_IDLE) |=> (st != ST_IDLE));

    // R10: debug halt freezes the count
    p_halt_freeze_r10: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (st == ST_RUN && halt_s && !new_cmd) |=> $stable(cnt));

    // R7: timer mode never requests a reset
    p_timer_no_reset_r7: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (st == ST_RUN && timer_mode) |=> (st != ST_FIRE));

    // R4: the pulse runs its full length
    p_pulse_len_r4: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (rst_req && pulse < PW'(PULSE_LEN - 1)) |=> rst_req);

    // R4: reset record is sticky and accompanies the pulse
    p_seen_sticky_r4: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        rst_seen |=> rst_seen);
    p_seen_with_req_r4: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        rst_req |-> rst_seen);
endmodule

// File: rtl/idwdg.sv
module idwdg
    import idwdg_pkg::*;
#(
    parameter int               DATA_W      = 16,
    parameter int               CNT_W       = 12,
    parameter int               PRE_W       = 8,
    parameter int               PSEL_W      = 3,
    parameter int               SYNC_STAGES = 2,
    parameter int               PULSE_LEN   = 4,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    input  logic              hw_start,
    input  logic              dbg_halt,
    output logic              rst_req,
    output logic              tmo_flag,
    output logic              rst_seen
);
    logic             req_tgl, req_s, ack_tgl, ack_s, halt_s;
    op_e              cmd_op;
    logic [CNT_W-1:0] cmd_data;

    idwdg_bus_if #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bus (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ack_tgl_s(ack_s), .req_tgl(req_tgl),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy)
    );

    idwdg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(req_tgl), .q(req_s)
    );

    idwdg_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(dbg_halt), .q(halt_s)
    );

    idwdg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
    );

    idwdg_core #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .PSEL_W(PSEL_W),
        .PULSE_LEN(PULSE_LEN), .RELOAD_INIT(RELOAD_INIT)
    ) u_core (
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .req_s(req_s), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .hw_start(hw_start), .halt_s(halt_s),
        .ack_tgl(ack_tgl), .rst_req(rst_req),
        .tmo_flag(tmo_flag), .rst_seen(rst_seen)
    );
endmodule

// File: tb/idwdg_tb.sv
`timescale 1ns/1ps
module idwdg_tb;
    logic        bus_clk = 1'b0, wd_clk = 1'b0;
    logic        bus_rst_n = 1'b0, wd_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        hw_start = 1'b0, dbg_halt = 1'b0;
    logic        busy, rst_req, tmo_flag, rst_seen;

    int checks = 0, failures = 0;
    int pulses = 0, cur_len = 0, last_len = 0;
    logic prev_rq = 1'b0;

    always #4  bus_clk = ~bus_clk;
    always #20 wd_clk  = ~wd_clk;

    idwdg #(.RELOAD_INIT(12'd15), .PULSE_LEN(4)) u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .hw_start(hw_start), .dbg_halt(dbg_halt),
        .rst_req(rst_req), .tmo_flag(tmo_flag), .rst_seen(rst_seen)
    );

    always @(negedge wd_clk) begin
        if (rst_req) begin
            if (!prev_rq) pulses <= pulses + 1;
            cur_len <= cur_len + 1;
        end else if (prev_rq) begin
            last_len <= cur_len;
            cur_len  <= 0;
        end
        prev_rq <= rst_req;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        bus_rst_n = 1'b0; wd_rst_n = 1'b0;
        hw_start = strap; dbg_halt = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge wd_clk);
        bus_rst_n = 1'b1; wd_rst_n = 1'b1;
        @(negedge wd_clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
        while (busy) @(negedge bus_clk);
        @(negedge wd_clk);
    endtask

    task automatic wait_wd(input int n);
        repeat (n) @(negedge wd_clk);
    endtask

    task automatic t_reset_state;
        int base;
        do_reset(1'b0);
        chk(rst_req == 0 && tmo_flag == 0 && rst_seen == 0 && busy == 0,
            "R1 reset outputs", {rst_req, tmo_flag, rst_seen, busy}, 0);
        base = pulses;
        wait_wd(200);
        chk(pulses == base, "R2 no reset without start", pulses - base, 0);
    endtask

    task automatic t_start_expiry;
        int base;
        do_reset(1'b0);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(55);
        chk(pulses == base, "R4 no early expiry", pulses - base, 0);
        wait_wd(20);
        chk(pulses == base + 1, "R2 start then expiry", pulses - base, 1);
        chk(last_len == 4, "R4 pulse length", last_len, 4);
        chk(rst_seen == 1, "R4 sticky record", rst_seen, 1);
    endtask

    task automatic t_strap;
        int base;
        do_reset(1'b1);
        base = pulses;
        wait_wd(80);
        chk(pulses == base + 1, "R3 strap start", pulses - base, 1);
        hw_start = 1'b0;
    endtask

    task automatic t_refresh;
        int base;
        do_reset(1'b0);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        for (int i = 0; i < 5; i++) begin
            wait_wd(40);
            bus_wr(2'd0, 16'hFEED);
        end
        chk(pulses == base, "R5 refreshed never fires", pulses - base, 0);
    endtask

    task automatic t_window;
        int base;
        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd3, 16'd5);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(8);
        bus_wr(2'd0, 16'hFEED);
        wait_wd(10);
        chk(pulses == base + 1, "R6 early refresh faults", pulses - base, 1);

        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd3, 16'd5);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(48);
        bus_wr(2'd0, 16'hFEED);
        wait_wd(40);
        chk(pulses == base, "R5 refresh inside window", pulses - base, 0);
    endtask

    task automatic t_timer_mode;
        int base;
        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd1, 16'h0008);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(80);
        chk(tmo_flag == 1, "R7 timeout flag set", tmo_flag, 1);
        chk(pulses == base && rst_seen == 0, "R7 no reset in timer mode", pulses - base, 0);
        wait_wd(4);
        bus_wr(2'd0, 16'hFEED);
        chk(tmo_flag == 0, "R7 refresh clears flag", tmo_flag, 0);
    endtask

    task automatic t_lock;
        int base;
        do_reset(1'b0);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd3;
        @(negedge bus_clk);
        wr_en = 1'b0;
        chk(busy == 0, "R8 locked write dropped", busy, 0);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(40);
        chk(pulses == base, "R8 locked reload ignored", pulses - base, 0);

        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd0, 16'h1234);
        bus_wr(2'd2, 16'd3);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(40);
        chk(pulses == base, "R8 relock ignores reload", pulses - base, 0);

        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd2, 16'd3);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(25);
        chk(pulses == base + 1, "R8 unlocked reload applied", pulses - base, 1);
    endtask

    task automatic t_prescaler;
        int base;
        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd1, 16'h0001);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(115);
        chk(pulses == base, "R9 div8 not yet", pulses - base, 0);
        wait_wd(25);
        chk(pulses == base + 1, "R9 div8 expiry", pulses - base, 1);

        do_reset(1'b0);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd1, 16'h0007);
        bus_wr(2'd2, 16'd0);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(240);
        chk(pulses == base, "R9 sel7 not yet", pulses - base, 0);
        wait_wd(35);
        chk(pulses == base + 1, "R9 sel7 divides by 256", pulses - base, 1);
    endtask

    task automatic t_halt;
        int base;
        do_reset(1'b0);
        base = pulses;
        bus_wr(2'd0, 16'hBEEF);
        wait_wd(20);
        dbg_halt = 1'b1;
        wait_wd(200);
        chk(pulses == base, "R10 halted no expiry", pulses - base, 0);
        dbg_halt = 1'b0;
        wait_wd(60);
        chk(pulses == base + 1, "R10 resumes after halt", pulses - base, 1);
    endtask

    task automatic t_no_stop_busy;
        int base;
        do_reset(1'b0);
        base = pulses;
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hBEEF;
        @(negedge bus_clk);
        wr_en = 1'b0;
        chk(busy == 1, "R12 busy after write", busy, 1);
        while (busy) @(negedge bus_clk);
        chk(busy == 0, "R12 busy clears", busy, 0);
        bus_wr(2'd0, 16'h0000);
        bus_wr(2'd0, 16'hC0DE);
        bus_wr(2'd1, 16'h0000);
        wait_wd(70);
        chk(pulses == base + 1, "R11 not stoppable", pulses - base, 1);
        wait_wd(70);
        chk(pulses == base + 2, "R11 keeps running after pulse", pulses - base, 2);
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_start_expiry();
        t_strap();
        t_refresh();
        t_window();
        t_timer_mode();
        t_lock();
        t_prescaler();
        t_halt();
        t_no_stop_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule